// File: doc/BRIEF.md
# Parallel Flash Bank Read Path

This block builds the word returned by a read from a bank of identical flash devices placed side by side on one data bus. The command unit keeps the current mode and the status byte. The array storage supplies the four bytes that start at the read address. For each read the block chooses one of four answers: array contents, the status byte copied into every device lane, the manufacturer or device code, or a byte from the built-in query table. It then lays that answer out for an access of 1, 2 or 4 bytes.

The bank width, device width, native (maximum) device width, byte order, geometry and secure option are all parameters. For ID and query reads the block scales the address for devices used below their native width. It builds each device's answer, copies that answer across the bank, and joins several bank-wide answers when the access is wider than the bank. A read that arrives with an unrecognised mode value returns array data and raises a one-cycle request to put the mode back to array reading. The result is registered once, so it appears one cycle after the request.

Top module: `flash_rd_path`

## Requirements
- R1: In array mode (0xFF) the result is built from `arr_bytes`, whose byte i holds the byte at address+i. With little-endian order, the byte at the lowest address sits in bits 7:0. With big-endian order, it sits in the most significant byte of the access. `rd_size` selects 1, 2 or 4 bytes (0, 1, 2), and all bits above the access are zero.
- R2: In any status mode (0x10, 0x20, 0x28, 0x40, 0x50, 0x60, 0x70, 0xE8), the status byte fills the lowest byte of every device-width lane inside the access. All other bits are zero.
- R3: For ID and query reads, the table offset is the address shifted right by log2(BANK_W) + log2(MAX_DEV_W) − log2(DEV_W).
- R4: In ID mode (0x90), an offset whose low eight bits equal 0 returns the manufacturer code. Low bits equal to 1 return the device code. Both codes are cut to the device width. Any other offset returns zero.
- R5: In query mode (0x98), the table holds "QRY" at 0x10–0x12, 0x01 at 0x13, 0x31 at 0x15, log2 of the per-device size at 0x27, 0x02 at 0x28, the buffer size log2 at 0x2A (0x08 for a one-byte bank, else 0x0B), block count minus one at 0x2D–0x2E, and per-device block size / 256 at 0x2F–0x30. It also holds "PRI10" at 0x31–0x35. Offsets above 0x3F return zero.
- R6: When DEV_W is below MAX_DEV_W, the query byte is repeated in every byte of the native device width rather than zero-padded.
- R7: Each single-device answer is copied into every device position of the bank.
- R8: An access wider than the bank is assembled from bank-wide answers at consecutive bank addresses. The lowest address goes in the lowest lanes.
- R9: Any other mode value is read as array mode, and `mode_clr` is asserted together with that result.
- R10: With SECURE_EN set, a read with `rd_secure` low returns array data whatever the mode, and `mode_clr` stays low.
- R11: `rd_valid` and the result appear exactly one cycle after `rd_en`. `rd_valid` is low otherwise, and all outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request this cycle |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_size | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| rd_secure | input | 1 | Read carries secure attribute |
| mode | input | 8 | Current command mode from the command unit |
| status | input | 8 | Current status byte |
| mfr_id | input | 16 | Manufacturer code |
| dev_id | input | 16 | Device code |
| arr_bytes | input | 32 | Array bytes at address+0..+3, byte i in bits 8i+7:8i |
| rd_data | output | 32 | Registered read result |
| rd_valid | output | 1 | Result valid |
| mode_clr | output | 1 | Request to return the mode to array reading |

## Verification
The assertions assume that `mode`, `status`, the ID codes and `arr_bytes` are stable in the cycle `rd_en` is high. They also assume that `rd_size` never takes the value 3. The stimulus meets both: it changes every input only on the falling edge, together with `rd_en`, and uses only sizes 0 to 2. The scoreboard checks two configurations in parallel on the same inputs. One is a four-byte little-endian bank of byte-wide devices run below a 16-bit native width. The other is a one-byte big-endian bank, where 4-byte accesses join four successive query bytes.

// File: rtl/flash_rd_path.sv
module flash_rd_path #(
  parameter int ADDR_W     = 16,
  parameter int BANK_W     = 4,
  parameter int DEV_W      = 1,
  parameter int MAX_DEV_W  = 2,
  parameter bit BIG_ENDIAN = 1'b0,
  parameter bit SECURE_EN  = 1'b0,
  parameter int SECT_BYTES = 65536,
  parameter int NUM_BLKS   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_size,
  input  logic              rd_secure,
  input  logic [7:0]        mode,
  input  logic [7:0]        status,
  input  logic [15:0]       mfr_id,
  input  logic [15:0]       dev_id,
  input  logic [31:0]       arr_bytes,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              mode_clr
);

  localparam int          NUM_DEV  = BANK_W / DEV_W;
  localparam int          SH       = $clog2(BANK_W) + $clog2(MAX_DEV_W) - $clog2(DEV_W);
  localparam logic [31:0] SPD      = 32'(SECT_BYTES / NUM_DEV);
  localparam logic [15:0] BLK_M1   = 16'(NUM_BLKS - 1);
  localparam logic [7:0]  SIZE_LOG = 8'($clog2(SECT_BYTES / NUM_DEV * NUM_BLKS));
  localparam logic [7:0]  WB_LOG   = (BANK_W == 1) ? 8'h08 : 8'h0B;
  localparam logic [7:0]  MODE_ARR = 8'hFF;
  localparam logic [7:0]  MODE_ID  = 8'h90;
  localparam logic [7:0]  MODE_QRY = 8'h98;

  function automatic logic [7:0] qbyte(input logic [ADDR_W-1:0] off);
    logic [7:0] b;
    b = 8'h00;
    if ((off >> 6) == '0) begin
      case (off[5:0])
        6'h10: b = 8'h51;
        6'h11: b = 8'h52;
        6'h12: b = 8'h59;
        6'h13: b = 8'h01;
        6'h15: b = 8'h31;
        6'h1B: b = 8'h45;
        6'h1C: b = 8'h55;
        6'h1F: b = 8'h07;
        6'h20: b = 8'h07;
        6'h21: b = 8'h0A;
        6'h23: b = 8'h04;
        6'h24: b = 8'h04;
        6'h25: b = 8'h04;
        6'h27: b = SIZE_LOG;
        6'h28: b = 8'h02;
        6'h2A: b = WB_LOG;
        6'h2C: b = 8'h01;
        6'h2D: b = BLK_M1[7:0];
        6'h2E: b = BLK_M1[15:8];
        6'h2F: b = SPD[15:8];
        6'h30: b = SPD[23:16];
        6'h31: b = 8'h50;
        6'h32: b = 8'h52;
        6'h33: b = 8'h49;
        6'h34: b = 8'h31;
        6'h35: b = 8'h30;
        6'h3F: b = 8'h01;
        default: b = 8'h00;
      endcase
    end
    return b;
  endfunction

  function automatic logic [31:0] bank_q(input logic [ADDR_W-1:0] a, input logic id,
                                         input logic [15:0] m, input logic [15:0] d);
    logic [ADDR_W-1:0] off;
    logic [31:0]       dw;
    logic [31:0]       r;
    off = a >> SH;
    if (id)
      dw = (off[7:0] == 8'd0) ? {16'h0, m} : (off[7:0] == 8'd1) ? {16'h0, d} : 32'h0;
    else if (DEV_W != MAX_DEV_W)
      dw = {4{qbyte(off)}};
    else
      dw = {24'h0, qbyte(off)};
    r = '0;
    for (int i = 0; i < BANK_W; i++) r[8*i +: 8] = dw[8*(i % DEV_W) +: 8];
    return r;
  endfunction

  logic        use_mode, is_status, id_low0;
  logic [2:0]  nbytes;
  logic [31:0] arr_word, stat_word, qry_word, raw, nxt_data;
  logic        nxt_clr;

  assign use_mode  = !SECURE_EN || rd_secure;
  assign nbytes    = (rd_size == 2'd0) ? 3'd1 : (rd_size == 2'd1) ? 3'd2 : 3'd4;
  assign is_status = (mode == 8'h10) || (mode == 8'h20) || (mode == 8'h28) || (mode == 8'h40) ||
                     (mode == 8'h50) || (mode == 8'h60) || (mode == 8'h70) || (mode == 8'hE8);
  assign id_low0   = ((rd_addr >> SH) & ADDR_W'(8'hFF)) == '0;

  always_comb begin
    logic [31:0] qr [4];
    if (!BIG_ENDIAN)
      arr_word = arr_bytes;
    else if (rd_size == 2'd0)
      arr_word = {24'h0, arr_bytes[7:0]};
    else if (rd_size == 2'd1)
      arr_word = {16'h0, arr_bytes[7:0], arr_bytes[15:8]};
    else
      arr_word = {arr_bytes[7:0], arr_bytes[15:8], arr_bytes[23:16], arr_bytes[31:24]};
    for (int j = 0; j < 4; j++)
      qr[j] = bank_q(rd_addr + ADDR_W'(j * BANK_W), mode == MODE_ID, mfr_id, dev_id);
    for (int k = 0; k < 4; k++) begin
      qry_word[8*k +: 8]  = qr[k / BANK_W][8*(k % BANK_W) +: 8];
      stat_word[8*k +: 8] = ((k % DEV_W) == 0) ? status : 8'h00;
    end
    nxt_clr = 1'b0;
    if (!use_mode)                                  raw = arr_word;
    else if (is_status)                             raw = stat_word;
    else if (mode == MODE_ID || mode == MODE_QRY)   raw = qry_word;
    else if (mode == MODE_ARR)                      raw = arr_word;
    else begin
      raw     = arr_word;
      nxt_clr = 1'b1;
    end
    for (int k = 0; k < 4; k++)
      nxt_data[8*k +: 8] = (k < int'(nbytes)) ? raw[8*k +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      mode_clr <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      mode_clr <= rd_en && nxt_clr;
      if (rd_en) rd_data <= nxt_data;
    end
  end

  // R11
  valid_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R11
  valid_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
  // R9
  clr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clr |-> rd_valid);
  // R1
  narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_size == 2'd0) |=> (rd_data[31:8] == 24'h0));
  // R2
  status_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && use_mode && is_status) |=> (rd_data[7:0] == $past(status)));
  // R10
  secure_no_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && SECURE_EN != 1'b0 && !rd_secure) |=> !mode_clr);
  // R4
  id_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && use_mode && mode == MODE_ID && id_low0) |=> (rd_data[7:0] == $past(mfr_id[7:0])));

endmodule

// File: tb/flash_rd_path_tb_top.sv
module flash_rd_path_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] exp_a;
    logic [31:0] exp_b;
    logic        exp_clr;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [1:0]  rd_size = '0;
  logic        rd_secure = 1'b1;
  logic [7:0]  mode = 8'hFF;
  logic [7:0]  status = 8'h80;
  logic [15:0] mfr_id = 16'h0089;
  logic [15:0] dev_id = 16'h0018;
  logic [31:0] arr_bytes = 32'h44332211;
  logic [31:0] rd_data, rd_data_b;
  logic        rd_valid, rd_valid_b, mode_clr, mode_clr_b;

  int errors = 0;
  int checks = 0;
  item_t sb [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_rd_path #(.BANK_W(4), .DEV_W(1), .MAX_DEV_W(2), .BIG_ENDIAN(1'b0), .SECURE_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_secure(rd_secure), .mode(mode), .status(status), .mfr_id(mfr_id), .dev_id(dev_id),
    .arr_bytes(arr_bytes), .rd_data(rd_data), .rd_valid(rd_valid), .mode_clr(mode_clr));

  flash_rd_path #(.BANK_W(1), .DEV_W(1), .MAX_DEV_W(1), .BIG_ENDIAN(1'b1), .SECURE_EN(1'b1)) dut_be_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_secure(rd_secure), .mode(mode), .status(status), .mfr_id(mfr_id), .dev_id(dev_id),
    .arr_bytes(arr_bytes), .rd_data(rd_data_b), .rd_valid(rd_valid_b), .mode_clr(mode_clr_b));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] sz, input logic [7:0] md,
                    input logic sec, input logic [7:0] st,
                    input logic [31:0] ea, input logic [31:0] eb, input logic ec, input string tag);
    item_t it;
    @(negedge clk);
    rd_addr = a; rd_size = sz; mode = md; rd_secure = sec; status = st; rd_en = 1'b1;
    it.exp_a = ea; it.exp_b = eb; it.exp_clr = ec; it.tag = tag;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R11 unexpected valid", 32'h1, 32'h0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(rd_data == it.exp_a, {it.tag, " bank4/le"}, rd_data, it.exp_a);
        check(rd_data_b == it.exp_b, {it.tag, " bank1/be"}, rd_data_b, it.exp_b);
        check(mode_clr == it.exp_clr, {it.tag, " mode_clr"}, 32'(mode_clr), 32'(it.exp_clr));
        check(rd_valid_b, {it.tag, " R11 valid bank1"}, 32'(rd_valid_b), 32'h1);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog: actual=%08h expected=%08h", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_valid == 1'b0 && rd_valid_b == 1'b0, "R11 reset valid", 32'(rd_valid), 32'h0);
    check(rd_data == 32'h0 && rd_data_b == 32'h0, "R11 reset data", rd_data, 32'h0);

    rd(16'h0000, 2'd2, 8'hFF, 1'b1, 8'h80, 32'h44332211, 32'h11223344, 1'b0, "R1 array x4");
    rd(16'h0000, 2'd1, 8'hFF, 1'b1, 8'h80, 32'h00002211, 32'h00001122, 1'b0, "R1 array x2");
    rd(16'h0000, 2'd0, 8'hFF, 1'b1, 8'h80, 32'h00000011, 32'h00000011, 1'b0, "R1 array x1");
    rd(16'h0000, 2'd2, 8'h70, 1'b1, 8'h80, 32'h80808080, 32'h80808080, 1'b0, "R2 status x4");
    rd(16'h0004, 2'd1, 8'h20, 1'b1, 8'h80, 32'h00008080, 32'h00008080, 1'b0, "R2 status x2");
    rd(16'h0004, 2'd0, 8'hE8, 1'b1, 8'h81, 32'h00000081, 32'h00000081, 1'b0, "R2 status x1");
    rd(16'h0000, 2'd2, 8'h90, 1'b1, 8'h80, 32'h89898989, 32'h00001889, 1'b0, "R4 R7 R8 id base");
    rd(16'h0008, 2'd2, 8'h90, 1'b1, 8'h80, 32'h18181818, 32'h00000000, 1'b0, "R3 R4 id device");
    rd(16'h0800, 2'd1, 8'h90, 1'b1, 8'h80, 32'h00008989, 32'h00001889, 1'b0, "R3 R4 id low byte");
    rd(16'h0080, 2'd2, 8'h98, 1'b1, 8'h80, 32'h51515151, 32'h00000000, 1'b0, "R6 R7 query Q");
    rd(16'h0138, 2'd2, 8'h98, 1'b1, 8'h80, 32'h14141414, 32'h00000000, 1'b0, "R5 query size");
    rd(16'h0010, 2'd2, 8'h98, 1'b1, 8'h80, 32'h00000000, 32'h01595251, 1'b0, "R5 R8 query QRY");
    rd(16'h0178, 2'd0, 8'h98, 1'b1, 8'h80, 32'h00000040, 32'h00000000, 1'b0, "R5 query blk size");
    rd(16'h002C, 2'd2, 8'h98, 1'b1, 8'h80, 32'h00000000, 32'h00003F01, 1'b0, "R5 R8 query region");
    rd(16'h0031, 2'd2, 8'h98, 1'b1, 8'h80, 32'h00000000, 32'h31495250, 1'b0, "R5 query ext");
    rd(16'h0150, 2'd2, 8'h98, 1'b1, 8'h80, 32'h0B0B0B0B, 32'h00000000, 1'b0, "R5 R6 query buffer");
    rd(16'h002A, 2'd0, 8'h98, 1'b1, 8'h80, 32'h00000000, 32'h00000008, 1'b0, "R5 query buffer b1");
    rd(16'h0027, 2'd0, 8'h98, 1'b1, 8'h80, 32'h00000000, 32'h00000016, 1'b0, "R5 query size b1");
    rd(16'h0200, 2'd2, 8'h98, 1'b1, 8'h80, 32'h00000000, 32'h00000000, 1'b0, "R5 query beyond");
    rd(16'h0000, 2'd2, 8'h00, 1'b1, 8'h80, 32'h44332211, 32'h11223344, 1'b1, "R9 unknown mode");
    rd(16'h0000, 2'd1, 8'h98, 1'b0, 8'h80, 32'h00002211, 32'h00001122, 1'b0, "R10 nonsecure query");
    rd(16'h0000, 2'd2, 8'h00, 1'b0, 8'h80, 32'h44332211, 32'h11223344, 1'b0, "R10 nonsecure unknown");
    @(negedge clk);
    rd_en = 1'b0;
    repeat (2) @(negedge clk);
    check(rd_valid == 1'b0 && rd_valid_b == 1'b0, "R11 idle valid", 32'(rd_valid), 32'h0);
    check(sb.size() == 0, "R11 all results seen", 32'(sb.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule